// File: doc/BRIEF.md
# Paired-Register File with Long Access

This block is the general-purpose register store for one datapath side of a wide-issue signal processor. It holds 32-bit registers and serves two independent single-register source reads each cycle, together with one destination write. A destination write can target a single register or a register pair. A pair is formed by an even register, which holds the low 32 bits, and the odd register directly above it, which holds the high bits. The even register number names the pair.

Pair transfers come in two widths. A 40-bit long value keeps its top 8 bits in the low byte of the odd register. The remaining 24 bits of that register are cleared on a long write and masked on a long read. A 64-bit double value fills both registers completely and needs two clock cycles, in both the write direction and the read direction. A pair specifier that names an odd register is rejected. Packed 8-bit or 16-bit lane data passes through the file unchanged, because the file never interprets lane boundaries.

A build parameter selects the register count. The base build has 16 registers and a 4-bit specifier. The extended build has 32 registers and a 5-bit specifier, and the top specifier bit selects the upper half of the file.

Top module: `pair_regfile`

## Requirements
- R1: While reset is asserted (`rst_ni` low), every register is cleared to zero, and all registers read zero after reset is released.
- R2: A single write (`dst_width_i` = 0) updates the named register at the clock edge. A source read in the same cycle returns the old value, and both source ports return the new value from the next cycle on.
- R3: With the extended build (default), the specifier is 5 bits wide and registers 16 to 31 are storage separate from registers 0 to 15.
- R4: A 40-bit write (`dst_width_i` = 1) to an even specifier n is performed in one cycle. Register n receives data bits 31..0. Register n+1 receives data bits 39..32 in its bits 7..0, and its bits 31..8 are forced to zero. Data bits 63..40 are ignored.
- R5: A 40-bit long read (`lrd_dbl_i` = 0) of even specifier n asserts `lrd_valid_o` for one cycle, in the cycle after the request. In that cycle, data bits 31..0 equal register n, bits 39..32 equal bits 7..0 of register n+1, and bits 63..40 are zero, whatever register n+1 holds above bit 7.
- R6: A 64-bit write (`dst_width_i` = 2) to even specifier n writes data bits 31..0 into register n at the accepting edge. `dst_busy_o` is then high for exactly one cycle, and at the end of that cycle data bits 63..32 are written into register n+1. A destination write presented while `dst_busy_o` is high is ignored.
- R7: A 64-bit long read (`lrd_dbl_i` = 1) of even specifier n holds `lrd_busy_o` high for the cycle after the request. `lrd_valid_o` is asserted one cycle later, with register n+1 in bits 63..32 and register n in bits 31..0. A long-read request presented while `lrd_busy_o` is high is ignored.
- R8: A pair write or long read whose specifier is odd raises the matching error output (`dst_err_o` or `lrd_err_o`) for one cycle, in the following cycle. The rejected request writes no register and produces no `lrd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src0_spec_i | input | SPEC_W | Source port 0 register specifier |
| src0_data_o | output | 32 | Source port 0 read data |
| src1_spec_i | input | SPEC_W | Source port 1 register specifier |
| src1_data_o | output | 32 | Source port 1 read data |
| dst_en_i | input | 1 | Destination write request |
| dst_spec_i | input | SPEC_W | Destination specifier (even register for pairs) |
| dst_width_i | input | 2 | 0 = 32-bit, 1 = 40-bit pair, 2 = 64-bit pair |
| dst_data_i | input | 64 | Destination write data |
| dst_busy_o | output | 1 | High half of a 64-bit write pending |
| dst_err_o | output | 1 | Odd specifier on a pair write |
| lrd_req_i | input | 1 | Long read request |
| lrd_spec_i | input | SPEC_W | Long read even specifier |
| lrd_dbl_i | input | 1 | 0 = 40-bit, 1 = 64-bit long read |
| lrd_data_o | output | 64 | Long read result |
| lrd_valid_o | output | 1 | Long read result valid |
| lrd_busy_o | output | 1 | 64-bit long read in its second cycle |
| lrd_err_o | output | 1 | Odd specifier on a long read |

## Verification
The assertions check the following on every cycle. The write busy flag lasts exactly one cycle and follows every accepted 64-bit write. An odd pair specifier always yields an error pulse without busy or valid. A 64-bit read busy cycle is always followed by valid. The top 24 bits of every 40-bit read result are zero. The values actually stored, namely the zero fill of the odd register on a 40-bit write, the split timing of the two halves of a 64-bit write, the old-value return on a same-cycle read, and the fact that rejected requests leave registers untouched, appear only through the bench's directed scenarios, which read the registers back through the source ports.

// File: rtl/pair_regfile_pkg.sv
package pair_regfile_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAIR_W = 2 * WORD_W;
  localparam int unsigned LONG_HI_W = 8;

  typedef enum logic [1:0] {
    WID_32 = 2'd0,
    WID_40 = 2'd1,
    WID_64 = 2'd2
  } dst_wid_e;
endpackage

// File: rtl/pair_regfile_bank.sv
module pair_regfile_bank
  import pair_regfile_pkg::*;
#(
  parameter int unsigned SPEC_W = 5,
  parameter int unsigned NRD    = 4,
  localparam int unsigned NUM_REGS = 1 << SPEC_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          w0_en_i,
  input  logic [SPEC_W-1:0]             w0_addr_i,
  input  logic [WORD_W-1:0]             w0_data_i,
  input  logic                          w1_en_i,
  input  logic [SPEC_W-1:0]             w1_addr_i,
  input  logic [WORD_W-1:0]             w1_data_i,
  input  logic [NRD-1:0][SPEC_W-1:0]    rd_addr_i,
  output logic [NRD-1:0][WORD_W-1:0]    rd_data_o
);
  logic [WORD_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[g] <= '0;
      else if (w1_en_i && w1_addr_i == SPEC_W'(g)) regs[g] <= w1_data_i;
      else if (w0_en_i && w0_addr_i == SPEC_W'(g)) regs[g] <= w0_data_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = regs[rd_addr_i[r]];
  end
endmodule

// File: rtl/pair_regfile_wr.sv
module pair_regfile_wr
  import pair_regfile_pkg::*;
#(
  parameter int unsigned SPEC_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SPEC_W-1:0]  spec_i,
  input  logic [1:0]         width_i,
  input  logic [PAIR_W-1:0]  data_i,
  output logic               w0_en_o,
  output logic [SPEC_W-1:0]  w0_addr_o,
  output logic [WORD_W-1:0]  w0_data_o,
  output logic               w1_en_o,
  output logic [SPEC_W-1:0]  w1_addr_o,
  output logic [WORD_W-1:0]  w1_data_o,
  output logic               busy_o,
  output logic               err_o
);
  logic              busy_q, err_q;
  logic [SPEC_W-1:0] hi_addr_q;
  logic [WORD_W-1:0] hi_data_q;
  logic accept, is_pair, illegal, go, go40, go64;
  logic [SPEC_W-1:0] odd_addr;

  assign accept   = en_i && !busy_q;
  assign is_pair  = (width_i == WID_40) || (width_i == WID_64);
  assign illegal  = accept && is_pair && spec_i[0];
  assign go       = accept && !illegal;
  assign go40     = go && (width_i == WID_40);
  assign go64     = go && (width_i == WID_64);
  assign odd_addr = {spec_i[SPEC_W-1:1], 1'b1};

  assign w0_en_o   = go;
  assign w0_addr_o = spec_i;
  assign w0_data_o = data_i[WORD_W-1:0];

  // pending high half wins; a new 40-bit write cannot coexist with it
  always_comb begin
    w1_en_o   = 1'b0;
    w1_addr_o = odd_addr;
    w1_data_o = {{(WORD_W-LONG_HI_W){1'b0}}, data_i[WORD_W+LONG_HI_W-1:WORD_W]};
    if (busy_q) begin
      w1_en_o   = 1'b1;
      w1_addr_o = hi_addr_q;
      w1_data_o = hi_data_q;
    end else if (go40) begin
      w1_en_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      hi_addr_q <= '0;
      hi_data_q <= '0;
    end else begin
      busy_q <= go64;
      err_q  <= illegal;
      if (go64) begin
        hi_addr_q <= odd_addr;
        hi_data_q <= data_i[PAIR_W-1:WORD_W];
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pair_regfile_lrd.sv
module pair_regfile_lrd
  import pair_regfile_pkg::*;
#(
  parameter int unsigned SPEC_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [SPEC_W-1:0]  spec_i,
  input  logic               dbl_i,
  output logic [SPEC_W-1:0]  lo_addr_o,
  output logic [SPEC_W-1:0]  hi_addr_o,
  input  logic [WORD_W-1:0]  lo_data_i,
  input  logic [WORD_W-1:0]  hi_data_i,
  output logic [PAIR_W-1:0]  data_o,
  output logic               valid_o,
  output logic               busy_o,
  output logic               err_o
);
  logic              busy_q, valid_q, err_q;
  logic [SPEC_W-1:0] hold_q;
  logic [WORD_W-1:0] low_q;
  logic [PAIR_W-1:0] data_q;
  logic accept, illegal, go;

  assign accept  = req_i && !busy_q;
  assign illegal = accept && spec_i[0];
  assign go      = accept && !illegal;

  assign lo_addr_o = spec_i;
  assign hi_addr_o = busy_q ? {hold_q[SPEC_W-1:1], 1'b1} : {spec_i[SPEC_W-1:1], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      hold_q  <= '0;
      low_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= illegal;
      if (busy_q) begin
        data_q  <= {hi_data_i, low_q};
        valid_q <= 1'b1;
        busy_q  <= 1'b0;
      end else if (go) begin
        if (dbl_i) begin
          low_q  <= lo_data_i;
          hold_q <= spec_i;
          busy_q <= 1'b1;
        end else begin
          // upper 24 bits of the odd register are masked
          data_q  <= {{(PAIR_W-WORD_W-LONG_HI_W){1'b0}}, hi_data_i[LONG_HI_W-1:0], lo_data_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign busy_o  = busy_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import pair_regfile_pkg::*;
#(
  parameter bit EXT_EN = 1'b1,
  localparam int unsigned SPEC_W = EXT_EN ? 5 : 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPEC_W-1:0] src0_spec_i,
  output logic [31:0]       src0_data_o,
  input  logic [SPEC_W-1:0] src1_spec_i,
  output logic [31:0]       src1_data_o,
  input  logic              dst_en_i,
  input  logic [SPEC_W-1:0] dst_spec_i,
  input  logic [1:0]        dst_width_i,
  input  logic [63:0]       dst_data_i,
  output logic              dst_busy_o,
  output logic              dst_err_o,
  input  logic              lrd_req_i,
  input  logic [SPEC_W-1:0] lrd_spec_i,
  input  logic              lrd_dbl_i,
  output logic [63:0]       lrd_data_o,
  output logic              lrd_valid_o,
  output logic              lrd_busy_o,
  output logic              lrd_err_o
);
  localparam int unsigned NRD = 4;

  logic              w0_en, w1_en;
  logic [SPEC_W-1:0] w0_addr, w1_addr, lo_addr, hi_addr;
  logic [WORD_W-1:0] w0_data, w1_data;
  logic [NRD-1:0][SPEC_W-1:0] rd_addr;
  logic [NRD-1:0][WORD_W-1:0] rd_data;

  assign rd_addr = {hi_addr, lo_addr, src1_spec_i, src0_spec_i};
  assign src0_data_o = rd_data[0];
  assign src1_data_o = rd_data[1];

  pair_regfile_wr #(.SPEC_W(SPEC_W)) i_wr (
    .clk_i, .rst_ni,
    .en_i(dst_en_i), .spec_i(dst_spec_i), .width_i(dst_width_i), .data_i(dst_data_i),
    .w0_en_o(w0_en), .w0_addr_o(w0_addr), .w0_data_o(w0_data),
    .w1_en_o(w1_en), .w1_addr_o(w1_addr), .w1_data_o(w1_data),
    .busy_o(dst_busy_o), .err_o(dst_err_o)
  );

  pair_regfile_lrd #(.SPEC_W(SPEC_W)) i_lrd (
    .clk_i, .rst_ni,
    .req_i(lrd_req_i), .spec_i(lrd_spec_i), .dbl_i(lrd_dbl_i),
    .lo_addr_o(lo_addr), .hi_addr_o(hi_addr),
    .lo_data_i(rd_data[2]), .hi_data_i(rd_data[3]),
    .data_o(lrd_data_o), .valid_o(lrd_valid_o), .busy_o(lrd_busy_o), .err_o(lrd_err_o)
  );

  pair_regfile_bank #(.SPEC_W(SPEC_W), .NRD(NRD)) i_bank (
    .clk_i, .rst_ni,
    .w0_en_i(w0_en), .w0_addr_i(w0_addr), .w0_data_i(w0_data),
    .w1_en_i(w1_en), .w1_addr_i(w1_addr), .w1_data_i(w1_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );
endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk #(
  parameter int unsigned SPEC_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dst_en_i,
  input logic [SPEC_W-1:0] dst_spec_i,
  input logic [1:0]        dst_width_i,
  input logic              dst_busy_o,
  input logic              dst_err_o,
  input logic              lrd_req_i,
  input logic [SPEC_W-1:0] lrd_spec_i,
  input logic [63:0]       lrd_data_o,
  input logic              lrd_valid_o,
  input logic              lrd_busy_o,
  input logic              lrd_err_o
);
  a_r6_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_busy_o |=> !dst_busy_o);

  a_r6_busy_after_dbl_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_en_i && !dst_busy_o && dst_width_i == 2'd2 && !dst_spec_i[0]) |=> dst_busy_o);

  a_r8_wr_odd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_en_i && !dst_busy_o && (dst_width_i == 2'd1 || dst_width_i == 2'd2) && dst_spec_i[0])
      |=> (dst_err_o && !dst_busy_o));

  a_r8_rd_odd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrd_req_i && !lrd_busy_o && lrd_spec_i[0]) |=> (lrd_err_o && !lrd_valid_o && !lrd_busy_o));

  a_r7_busy_then_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrd_busy_o |=> (lrd_valid_o && !lrd_busy_o));

  a_r5_long_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrd_valid_o && !$past(lrd_busy_o)) |-> (lrd_data_o[63:40] == 24'd0));
endmodule

bind pair_regfile pair_regfile_chk #(.SPEC_W(SPEC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .dst_en_i(dst_en_i), .dst_spec_i(dst_spec_i), .dst_width_i(dst_width_i),
  .dst_busy_o(dst_busy_o), .dst_err_o(dst_err_o),
  .lrd_req_i(lrd_req_i), .lrd_spec_i(lrd_spec_i), .lrd_data_o(lrd_data_o),
  .lrd_valid_o(lrd_valid_o), .lrd_busy_o(lrd_busy_o), .lrd_err_o(lrd_err_o)
);

// File: tb/test_pair_regfile.sv
module test_pair_regfile;
  localparam time CYC = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  src0_spec_i = '0, src1_spec_i = '0, dst_spec_i = '0, lrd_spec_i = '0;
  logic [31:0] src0_data_o, src1_data_o;
  logic        dst_en_i = 1'b0, lrd_req_i = 1'b0, lrd_dbl_i = 1'b0;
  logic [1:0]  dst_width_i = '0;
  logic [63:0] dst_data_i = '0, lrd_data_o;
  logic        dst_busy_o, dst_err_o, lrd_valid_o, lrd_busy_o, lrd_err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CYC/2) clk_i = ~clk_i;

  pair_regfile i_pair_regfile (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_is(string tag, logic [4:0] a, logic [31:0] exp);
    src0_spec_i = a;
    #1;
    chk(tag, 64'(src0_data_o), 64'(exp));
  endtask

  task automatic wr(logic [4:0] a, logic [1:0] w, logic [63:0] d);
    @(negedge clk_i);
    dst_en_i = 1'b1; dst_spec_i = a; dst_width_i = w; dst_data_i = d;
    @(negedge clk_i);
    dst_en_i = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) reg_is("R1 reset zero", 5'(i), 32'd0);
    chk("R1 flags idle", {60'd0, dst_busy_o, dst_err_o, lrd_valid_o, lrd_busy_o}, 64'd0);
  endtask

  task automatic t_single;
    @(negedge clk_i);
    dst_en_i = 1'b1; dst_spec_i = 5'd3; dst_width_i = 2'd0; dst_data_i = 64'hFFFF_0000_CAFE_0003;
    reg_is("R2 same-cycle old value", 5'd3, 32'd0);
    @(negedge clk_i);
    dst_en_i = 1'b0;
    reg_is("R2 port0 new value", 5'd3, 32'hCAFE_0003);
    src1_spec_i = 5'd3; #1;
    chk("R2 port1 new value", 64'(src1_data_o), 64'h0000_0000_CAFE_0003);
  endtask

  task automatic t_ext;
    wr(5'd19, 2'd0, 64'h0000_0000_1919_1919);
    reg_is("R3 upper register", 5'd19, 32'h1919_1919);
    reg_is("R3 lower alias untouched", 5'd3, 32'hCAFE_0003);
  endtask

  task automatic t_w40;
    wr(5'd7, 2'd0, 64'h0000_0000_FFFF_FFFF);
    wr(5'd6, 2'd1, 64'hDEAD_BE5A_1234_5678);
    reg_is("R4 even low word", 5'd6, 32'h1234_5678);
    reg_is("R4 odd zero fill", 5'd7, 32'h0000_005A);
  endtask

  task automatic t_r40;
    wr(5'd9, 2'd0, 64'h0000_0000_ABCD_EF77);
    wr(5'd8, 2'd0, 64'h0000_0000_0BAD_F00D);
    @(negedge clk_i);
    lrd_req_i = 1'b1; lrd_spec_i = 5'd8; lrd_dbl_i = 1'b0;
    @(negedge clk_i);
    lrd_req_i = 1'b0;
    chk("R5 valid next cycle", 64'(lrd_valid_o), 64'd1);
    chk("R5 masked data", lrd_data_o, 64'h0000_0077_0BAD_F00D);
    @(negedge clk_i);
    chk("R5 valid one cycle", 64'(lrd_valid_o), 64'd0);
  endtask

  task automatic t_w64;
    @(negedge clk_i);
    dst_en_i = 1'b1; dst_spec_i = 5'd10; dst_width_i = 2'd2; dst_data_i = 64'h1111_2222_3333_4444;
    @(negedge clk_i);
    chk("R6 busy", 64'(dst_busy_o), 64'd1);
    reg_is("R6 low half first", 5'd10, 32'h3333_4444);
    reg_is("R6 high half not yet", 5'd11, 32'd0);
    dst_spec_i = 5'd12; dst_width_i = 2'd0; dst_data_i = 64'h0000_0000_FFFF_FFFF;
    @(negedge clk_i);
    dst_en_i = 1'b0;
    chk("R6 busy cleared", 64'(dst_busy_o), 64'd0);
    reg_is("R6 high half second", 5'd11, 32'h1111_2222);
    reg_is("R6 write during busy ignored", 5'd12, 32'd0);
  endtask

  task automatic t_r64;
    @(negedge clk_i);
    lrd_req_i = 1'b1; lrd_spec_i = 5'd10; lrd_dbl_i = 1'b1;
    @(negedge clk_i);
    chk("R7 busy", 64'(lrd_busy_o), 64'd1);
    chk("R7 not valid yet", 64'(lrd_valid_o), 64'd0);
    lrd_spec_i = 5'd6; lrd_dbl_i = 1'b0;
    @(negedge clk_i);
    lrd_req_i = 1'b0;
    chk("R7 valid", 64'(lrd_valid_o), 64'd1);
    chk("R7 data", lrd_data_o, 64'h1111_2222_3333_4444);
    @(negedge clk_i);
    chk("R7 request during busy ignored", 64'(lrd_valid_o), 64'd0);
  endtask

  task automatic t_err;
    wr(5'd13, 2'd0, 64'h0000_0000_0000_C0C0);
    wr(5'd14, 2'd0, 64'h0000_0000_0000_D0D0);
    @(negedge clk_i);
    dst_en_i = 1'b1; dst_spec_i = 5'd13; dst_width_i = 2'd1; dst_data_i = 64'h0000_00EE_EEEE_EEEE;
    @(negedge clk_i);
    dst_en_i = 1'b0;
    chk("R8 write error", 64'(dst_err_o), 64'd1);
    reg_is("R8 odd reg untouched", 5'd13, 32'h0000_C0C0);
    reg_is("R8 next reg untouched", 5'd14, 32'h0000_D0D0);
    @(negedge clk_i);
    chk("R8 write error one cycle", 64'(dst_err_o), 64'd0);
    lrd_req_i = 1'b1; lrd_spec_i = 5'd5; lrd_dbl_i = 1'b1;
    @(negedge clk_i);
    lrd_req_i = 1'b0;
    chk("R8 read error", 64'(lrd_err_o), 64'd1);
    chk("R8 read no valid", 64'(lrd_valid_o), 64'd0);
    chk("R8 read no busy", 64'(lrd_busy_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_single;
    t_ext;
    t_w40;
    t_r40;
    t_w64;
    t_r64;
    t_err;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule